// File: doc/BRIEF.md
# Quadrature Position Tracker with Four-Digit Decimal Readout

This block follows the shaft angle of a motor through a two-phase incremental encoder. It keeps a 12-bit position count and shows that count as four decimal digits, each coded for a seven-segment display. The phases are synchronised with two flops. A four-state machine then decodes each step into a one-cycle up or down pulse, and the pulse moves a wrapping counter by one.

A converter works alongside the counter and never stops. It takes a snapshot of the position and splits it into thousands, hundreds, tens and units. It does this by subtracting the weight of each decade over many cycles. When the split is done, all four digits go to the segment encoders in the same clock. The displayed digits therefore never show a partly converted value.

The encoder phases are plain level inputs and the outputs are plain registered levels. The block has no valid/ready stream and no back-pressure. The converter always runs again right away, so the display follows the position with a short, fixed lag.

Top module: `qdr_readout_top`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and after it is released, position is 0. Every segment output is 7'b0111111, which lights only the middle bar. The tracker starts in the code (A,B)=10.
- R2: A step forward through the code cycle 10→11→01→00→10 adds one to position.
- R3: A step to the previous code in that cycle, for example 10→00 or 11→10, subtracts one from position.
- R4: A code that does not change leaves position unchanged.
- R5: A change in which both A and B flip in the same step is invalid. It leaves position unchanged, and the tracker adopts the new code, so the next step is judged from that code.
- R6: Each valid step raises exactly one of the internal up and down pulses, for exactly one clock.
- R7: Position wraps modulo 4096: a step up from 4095 gives 0, and a step down from 0 gives 4095.
- R8: Each segment output shows its decimal digit of position, active low, with bit 6 = g through bit 0 = a. The codes are 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000.
- R9: All four segment outputs change in the same clock, and only when a conversion finishes. In between they hold the previous complete result.
- R10: Successive conversion results are at most 28 clocks apart. The worst case is 3999, and the next conversion starts at once.
- R11: A phase change that is driven between clock edges first reaches position on the fourth rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_a | input | 1 | Encoder phase A, asynchronous to clk |
| phase_b | input | 1 | Encoder phase B, asynchronous to clk |
| position | output | 12 | Current position count |
| seg_thou | output | 7 | Thousands digit, segments g..a, active low |
| seg_hund | output | 7 | Hundreds digit, segments g..a, active low |
| seg_tens | output | 7 | Tens digit, segments g..a, active low |
| seg_unit | output | 7 | Units digit, segments g..a, active low |

## Verification
The hardest case to reach from the pins is a conversion that is in flight while the position changes, because the display must not show a mix of the old and new digits. To create it, the stimulus moves the encoder one code and then samples all four segment outputs on every clock until the new result appears. Each sample must equal either the full old pattern or the full new one. The corner values 999, 1000, 1234, 0 and 4095 are reached with fast bursts of encoder steps that are two clocks apart. These values exercise the decade borrow and both wrap directions.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

  localparam int NUM_DIG = 4;
  localparam logic [6:0] SEG_BLANK = 7'b0111111;

  // next code in the forward direction of travel
  function automatic logic [1:0] fwd_code(input logic [1:0] c);
    case (c)
      2'b10:   fwd_code = 2'b11;
      2'b11:   fwd_code = 2'b01;
      2'b01:   fwd_code = 2'b00;
      default: fwd_code = 2'b10;
    endcase
  endfunction

  function automatic logic [31:0] pow10(input int n);
    logic [31:0] r;
    r = 32'd1;
    for (int k = 0; k < n; k++) r = r * 32'd10;
    return r;
  endfunction

  // active-low segments, bit 6 = g ... bit 0 = a
  function automatic logic [6:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0:    seg_of = 7'b1000000;
      4'd1:    seg_of = 7'b1111001;
      4'd2:    seg_of = 7'b0100100;
      4'd3:    seg_of = 7'b0110000;
      4'd4:    seg_of = 7'b0011001;
      4'd5:    seg_of = 7'b0010010;
      4'd6:    seg_of = 7'b0000010;
      4'd7:    seg_of = 7'b1111000;
      4'd8:    seg_of = 7'b0000000;
      4'd9:    seg_of = 7'b0010000;
      default: seg_of = SEG_BLANK;
    endcase
  endfunction

endpackage

// File: rtl/qdr_sync.sv
module qdr_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q_o  <= INIT;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/qdr_quad_fsm.sv
module qdr_quad_fsm
  import qdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_i,
  output logic       up_o,
  output logic       dn_o
);
  logic [1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= 2'b10;
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
      if (code_i == fwd_code(st)) begin
        up_o <= 1'b1;
      end else if (fwd_code(code_i) == st) begin
        dn_o <= 1'b1;
      end
      // same code keeps the state; a double flip re-aligns without a count
      st <= code_i;
    end
  end
endmodule

// File: rtl/qdr_dec_conv.sv
module qdr_dec_conv
  import qdr_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [POS_W-1:0]          pos_i,
  output logic [NUM_DIG-1:0][3:0]   dig_o,
  output logic                      done_o
);
  localparam int IDX_W = $clog2(NUM_DIG);

  typedef enum logic [2:0] {C_SNAP, C_CLEAR, C_SUB, C_LAST, C_PUB} cstate_t;

  cstate_t                    cs;
  logic [POS_W-1:0]           rem;
  logic [IDX_W-1:0]           idx;
  logic [NUM_DIG-1:0][3:0]    acc;
  logic [31:0]                weight;

  always_comb weight = pow10(int'(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs     <= C_SNAP;
      rem    <= '0;
      idx    <= '0;
      acc    <= '0;
      dig_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (cs)
        C_SNAP: begin
          rem <= pos_i;
          cs  <= C_CLEAR;
        end
        C_CLEAR: begin
          acc <= '0;
          idx <= IDX_W'(NUM_DIG - 1);
          cs  <= C_SUB;
        end
        C_SUB: begin
          if (32'(rem) >= weight) begin
            rem      <= rem - weight[POS_W-1:0];
            acc[idx] <= acc[idx] + 4'd1;
          end else if (idx == IDX_W'(1)) begin
            cs <= C_LAST;
          end else begin
            idx <= idx - IDX_W'(1);
          end
        end
        C_LAST: begin
          acc[0] <= rem[3:0];
          cs     <= C_PUB;
        end
        default: begin
          dig_o  <= acc;
          done_o <= 1'b1;
          cs     <= C_SNAP;
        end
      endcase
    end
  end
endmodule

// File: rtl/qdr_seg_digit.sv
module qdr_seg_digit
  import qdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [3:0] digit_i,
  output logic [6:0] seg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seg_o <= SEG_BLANK;
    else if (load_i) seg_o <= seg_of(digit_i);
  end
endmodule

// File: rtl/qdr_readout_top.sv
module qdr_readout_top
  import qdr_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  output logic [POS_W-1:0] position,
  output logic [6:0]       seg_thou,
  output logic [6:0]       seg_hund,
  output logic [6:0]       seg_tens,
  output logic [6:0]       seg_unit
);
  logic [1:0]              code_s;
  logic                    up_pls;
  logic                    dn_pls;
  logic [NUM_DIG-1:0][3:0] digits;
  logic                    cnv_done;
  logic [NUM_DIG-1:0][6:0] seg_all;

  qdr_sync #(.W(2), .INIT(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({phase_a, phase_b}), .q_o(code_s)
  );

  qdr_quad_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .code_i(code_s), .up_o(up_pls), .dn_o(dn_pls)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      position <= '0;
    else if (up_pls) position <= position + POS_W'(1);
    else if (dn_pls) position <= position - POS_W'(1);
  end

  qdr_dec_conv #(.POS_W(POS_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .pos_i(position), .dig_o(digits), .done_o(cnv_done)
  );

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_seg
    qdr_seg_digit u_seg (
      .clk(clk), .rst_n(rst_n), .load_i(cnv_done),
      .digit_i(digits[g]), .seg_o(seg_all[g])
    );
  end

  assign seg_unit = seg_all[0];
  assign seg_tens = seg_all[1];
  assign seg_hund = seg_all[2];
  assign seg_thou = seg_all[3];
endmodule

// File: rtl/qdr_readout_chk.sv
module qdr_readout_chk #(
  parameter int POS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up,
  input logic             dn,
  input logic [POS_W-1:0] pos,
  input logic             done,
  input logic [27:0]      segs
);
  logic [5:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap <= '0;
    else if (done) gap <= '0;
    else if (gap != 6'h3f) gap <= gap + 6'd1;
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn)); // R6
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n) up |=> pos == POS_W'($past(pos) + POS_W'(1))); // R2
  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n) dn |=> pos == POS_W'($past(pos) - POS_W'(1))); // R3
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!up && !dn) |=> $stable(pos)); // R4
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(segs)); // R9
  AST_CONV_BOUND: assert property (@(posedge clk) disable iff (!rst_n) gap < 6'd28); // R10
endmodule

bind qdr_readout_top qdr_readout_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up(up_pls), .dn(dn_pls), .pos(position),
  .done(cnv_done), .segs({seg_thou, seg_hund, seg_tens, seg_unit})
);

// File: tb/qdr_readout_top_tb.sv
module qdr_readout_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ph = 2'b10;
  logic [11:0] position;
  logic [6:0]  seg_thou, seg_hund, seg_tens, seg_unit;

  int n_run = 0;
  int n_fail = 0;
  int model_pos = 0;
  bit drv_done = 1'b0;

  typedef struct { int pos; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  qdr_readout_top u_dut (
    .clk(clk), .rst_n(rst_n), .phase_a(ph[1]), .phase_b(ph[0]),
    .position(position), .seg_thou(seg_thou), .seg_hund(seg_hund),
    .seg_tens(seg_tens), .seg_unit(seg_unit)
  );

  function automatic logic [6:0] ref_seg(input int d);
    case (d)
      0: return 7'b1000000;  1: return 7'b1111001;
      2: return 7'b0100100;  3: return 7'b0110000;
      4: return 7'b0011001;  5: return 7'b0010010;
      6: return 7'b0000010;  7: return 7'b1111000;
      8: return 7'b0000000;  default: return 7'b0010000;
    endcase
  endfunction

  function automatic logic [27:0] ref_all(input int p);
    return {ref_seg(p / 1000), ref_seg((p / 100) % 10),
            ref_seg((p / 10) % 10), ref_seg(p % 10)};
  endfunction

  function automatic logic [1:0] ref_next(input logic [1:0] c);
    case (c)
      2'b10: return 2'b11;  2'b11: return 2'b01;
      2'b01: return 2'b00;  default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] ref_prev(input logic [1:0] c);
    case (c)
      2'b11: return 2'b10;  2'b01: return 2'b11;
      2'b00: return 2'b01;  default: return 2'b00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one code; watch display stays whole until settled; push expectation
  task automatic move(input logic [1:0] code, input int delta, input string tag);
    logic [27:0] old_s, new_s, cur;
    bit whole;
    old_s = ref_all(model_pos);
    @(negedge clk);
    ph = code;
    model_pos = (model_pos + delta + 4096) % 4096;
    new_s = ref_all(model_pos);
    whole = 1'b1;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      cur = {seg_thou, seg_hund, seg_tens, seg_unit};
      if (cur != old_s && cur != new_s) whole = 1'b0;
    end
    check(whole, "R9", {tag, " display whole during update"}, int'(whole), 1);
    sb_q.push_back('{model_pos, tag});
  endtask

  task automatic burst(input int n, input bit fwd, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ph = fwd ? ref_next(ph) : ref_prev(ph);
      model_pos = (model_pos + (fwd ? 1 : -1) + 4096) % 4096;
      @(negedge clk);
    end
    repeat (70) @(negedge clk);
    sb_q.push_back('{model_pos, tag});
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    item_t it;
    logic [27:0] exp_s;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        exp_s = ref_all(it.pos);
        check(int'(position) == it.pos, it.tag, "position", int'(position), it.pos);
        check({seg_thou, seg_hund, seg_tens, seg_unit} == exp_s, "R8",
              {it.tag, " segments"}, int'({seg_thou, seg_hund, seg_tens, seg_unit}),
              int'(exp_s));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(position == 12'd0, "R1", "position in reset", int'(position), 0);
    check({seg_thou, seg_hund, seg_tens, seg_unit} == {4{7'b0111111}}, "R1",
          "segments in reset", int'(seg_unit), int'(7'b0111111));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(position == 12'd0, "R1", "position after release", int'(position), 0);

    // R11: latency of a forward step from 10 to 11
    ph = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(position == 12'd0, "R11", "no change after 3 edges", int'(position), 0);
    @(posedge clk);
    @(negedge clk);
    check(position == 12'd1, "R11", "change on 4th edge", int'(position), 1);
    model_pos = 1;
    repeat (70) @(negedge clk);
    sb_q.push_back('{1, "R2 first up"});

    move(2'b01, 1, "R2 up 11->01");
    move(2'b00, 1, "R2 up 01->00");
    move(2'b10, 1, "R2 up 00->10");
    move(2'b11, 1, "R2 up 10->11");
    move(2'b10, -1, "R3 down 11->10");
    move(2'b00, -1, "R3 down 10->00");
    move(2'b00, 0, "R4 same code");
    // R5: double flip 00->11 counts nothing, then 11->01 is a forward step
    move(2'b11, 0, "R5 double flip");
    move(2'b01, 1, "R5 step after realign");
    move(2'b11, -1, "R5 back step after realign");

    burst(model_pos, 1'b0, "R3 burst to zero");
    move(ref_prev(ph), -1, "R7 wrap 0 to 4095");
    move(ref_next(ph), 1, "R7 wrap 4095 to 0");
    burst(1234, 1'b1, "R8 value 1234");
    burst(234, 1'b0, "R8 value 1000");
    move(ref_prev(ph), -1, "R8 value 999");
    burst(3000, 1'b1, "R10 value 3999");

    repeat (5) @(negedge clk);
    drv_done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule